// File: doc/BRIEF.md
# Interrupt Stack-Switch Fault Checker

This block validates a privilege-raising interrupt or exception transfer that moves execution onto a new stack. Its inputs are the new stack selector and stack pointer taken from the task state table, the already-fetched fields of the stack segment descriptor, the privilege level of the target code segment, the gate width, whether an error code will be pushed, a long-mode flag, and the target instruction pointer together with the code segment limit. Descriptor fetches, gate decode and the stack pushes themselves happen elsewhere.

A one-cycle `start` pulse makes the checker latch every input. It then steps through its checks, one per clock, in a fixed order. The first check that fails ends the run. The block reports the fault vector and the error code that belongs to it. If every check passes, it reports success along with the selector and pointer to load as the active stack.

The sequencer states are IDLE, NULLCK, SELCK, DESCCK, PRESCK, STACKCK, IPCK and REPORT. A start pulse moves IDLE to NULLCK outside long mode, and IDLE to STACKCK in long mode. Each check state moves to REPORT when its check fails and to the next check when it passes, in the order NULLCK, SELCK, DESCCK, PRESCK, STACKCK, IPCK. IPCK always moves to REPORT, and REPORT always returns to IDLE.

Top module: `stack_switch_checker`

## Requirements
- R1: After reset, done, fault, vector, err_code, new_ss and new_sp are all zero.
- R2: The block accepts start only in IDLE and latches all inputs at that point. A start pulse while a run is in progress has no effect. done is high for exactly one cycle. It rises 7 clocks after start outside long mode when all checks pass, and 3 clocks after start in long mode when all checks pass.
- R3: Outside long mode, a null stack selector raises vector 10 with error code {15'b0, ext_evt}. A selector is null when sel[15:2] is zero, whatever its RPL.
- R4: Outside long mode, vector 10 is raised if the selector's last byte ({sel[15:3],3'b111}) exceeds tbl_limit, or if sel[1:0] differs from cs_dpl. The error code is {sel[15:2], 1'b0, ext_evt}.
- R5: Outside long mode, vector 10 with the selector error code is raised if ss_dpl differs from cs_dpl, or if the descriptor is not a writable data segment.
- R6: Outside long mode, a stack descriptor that is not present raises vector 12 with the selector error code.
- R7: For gate_kind 0 (16-bit) the stack needs 12 bytes of room with an error code and 10 without. For gate_kind 1 (32-bit) it needs 24 and 20. Room is present when the low 32 bits of the pointer are at least the needed count and at most ss_limit+1. Otherwise vector 12 with the selector error code is raised.
- R8: For gate_kind 2 or 3 (64-bit), a stack pointer whose bits 63..47 are not all equal raises vector 12 with error code 0.
- R9: Outside long mode, tgt_ip greater than cs_limit raises vector 13 with error code 0. In long mode, a tgt_ip whose bits 63..47 are not all equal raises vector 13 with error code 0.
- R10: When several checks would fail, only the first in the order null, index/RPL, descriptor, present, stack, instruction pointer is reported.
- R11: On success, fault, vector and err_code are 0 and new_sp equals the stack pointer. new_ss is the selector outside long mode and 0 in long mode. Long mode skips the selector and descriptor checks.
- R12: The results stay unchanged after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check run (IDLE only) |
| lm_active | input | 1 | Long mode active |
| gate_kind | input | 2 | 0=16-bit, 1=32-bit, 2/3=64-bit gate |
| push_err | input | 1 | An error code will be pushed |
| ext_evt | input | 1 | External-event bit for error codes |
| tss_sel | input | 16 | New stack selector from task state table |
| tss_sp | input | 64 | New stack pointer from task state table |
| tbl_limit | input | 16 | Descriptor table limit in bytes |
| cs_dpl | input | 2 | Target code segment privilege level |
| ss_dpl | input | 2 | Stack descriptor privilege level |
| ss_is_data | input | 1 | Stack descriptor is a data segment |
| ss_writable | input | 1 | Stack descriptor is writable |
| ss_present | input | 1 | Stack descriptor present |
| ss_limit | input | 32 | Stack segment limit |
| tgt_ip | input | 64 | Target instruction pointer |
| cs_limit | input | 32 | Code segment limit |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | A check failed |
| vector | output | 8 | Fault vector (10, 12, 13) or 0 |
| err_code | output | 16 | Error code of the fault |
| new_ss | output | 16 | Stack selector to load on success |
| new_sp | output | 64 | Stack pointer to load on success |

## Verification
The bench probes each room threshold exactly at the needed byte count and one byte below it, for both gate widths with and without an error code. A checker that swapped the 16-bit and 32-bit counts, or that compared with the wrong strictness, would accept a short stack or reject a legal one. It also tests the upper bound at ss_limit+1 and one byte past it, and the code limit exactly at cs_limit. An off-by-one there would either corrupt memory above the segment or fault on a legal transfer. Canonical addresses are tested on both sides of the bit-47 boundary. Stimuli that combine several failing checks confirm that priority picks the earlier fault rather than a later vector. Other tests confirm that long mode really skips the selector checks, that a start pulse mid-run changes nothing, and that the ext bit lands in bit 0 while the RPL bits are cleared.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_NULLCK, S_SELCK, S_DESCCK, S_PRESCK, S_STACKCK, S_IPCK, S_REPORT
    } ssw_state_t;

    localparam logic [7:0] VEC_NONE = 8'd0;
    localparam logic [7:0] VEC_TS   = 8'd10;
    localparam logic [7:0] VEC_SS   = 8'd12;
    localparam logic [7:0] VEC_GP   = 8'd13;

    localparam logic [1:0] GATE_16 = 2'd0;
    localparam logic [1:0] GATE_32 = 2'd1;
endpackage

// File: rtl/ssw_canon.sv
module ssw_canon #(
    parameter int HI_W = 17
) (
    input  logic [HI_W-1:0] hi_bits,
    output logic            canon_ok
);
    always_comb canon_ok = (&hi_bits) | ~(|hi_bits);
endmodule

// File: rtl/ssw_room.sv
module ssw_room #(
    parameter int LIM_W = 32
) (
    input  logic [1:0]       gate_kind,
    input  logic             push_err,
    input  logic [LIM_W-1:0] sp_lo,
    input  logic [LIM_W-1:0] seg_limit,
    output logic             room_ok
);
    import ssw_pkg::*;
    localparam int EXT_W = LIM_W + 1;

    logic [EXT_W-1:0] need_bytes;
    logic [EXT_W-1:0] top_bound;

    always_comb begin
        if (gate_kind == GATE_16)
            need_bytes = push_err ? EXT_W'(12) : EXT_W'(10);
        else
            need_bytes = push_err ? EXT_W'(24) : EXT_W'(20);
        top_bound = {1'b0, seg_limit} + EXT_W'(1);
        room_ok   = ({1'b0, sp_lo} >= need_bytes) && ({1'b0, sp_lo} <= top_bound);
    end
endmodule

// File: rtl/ssw_seg_check.sv
module ssw_seg_check #(
    parameter int SEL_W = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [SEL_W-1:0] tbl_limit,
    input  logic [1:0]       cs_dpl,
    input  logic [1:0]       ss_dpl,
    input  logic             ss_is_data,
    input  logic             ss_writable,
    input  logic             ss_present,
    input  logic             ext_evt,
    output logic             is_null,
    output logic             sel_bad,
    output logic             desc_bad,
    output logic             not_present,
    output logic [SEL_W-1:0] null_err,
    output logic [SEL_W-1:0] sel_err
);
    logic [SEL_W-1:0] last_byte;

    always_comb begin
        last_byte   = {sel[SEL_W-1:3], 3'b111};
        is_null     = (sel[SEL_W-1:2] == '0);
        sel_bad     = (last_byte > tbl_limit) || (sel[1:0] != cs_dpl);
        desc_bad    = (ss_dpl != cs_dpl) || !(ss_is_data && ss_writable);
        not_present = !ss_present;
        null_err    = {{(SEL_W-1){1'b0}}, ext_evt};
        sel_err     = {sel[SEL_W-1:2], 1'b0, ext_evt};
    end
endmodule

// File: rtl/stack_switch_checker.sv
module stack_switch_checker #(
    parameter int SEL_W   = 16,
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48,
    parameter int LIM_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              lm_active,
    input  logic [1:0]        gate_kind,
    input  logic              push_err,
    input  logic              ext_evt,
    input  logic [SEL_W-1:0]  tss_sel,
    input  logic [ADDR_W-1:0] tss_sp,
    input  logic [SEL_W-1:0]  tbl_limit,
    input  logic [1:0]        cs_dpl,
    input  logic [1:0]        ss_dpl,
    input  logic              ss_is_data,
    input  logic              ss_writable,
    input  logic              ss_present,
    input  logic [LIM_W-1:0]  ss_limit,
    input  logic [ADDR_W-1:0] tgt_ip,
    input  logic [LIM_W-1:0]  cs_limit,
    output logic              done,
    output logic              fault,
    output logic [7:0]        vector,
    output logic [SEL_W-1:0]  err_code,
    output logic [SEL_W-1:0]  new_ss,
    output logic [ADDR_W-1:0] new_sp
);
    import ssw_pkg::*;
    localparam int HI_W = ADDR_W - VA_BITS + 1;

    ssw_state_t state, state_nx;

    // latched request
    logic              q_lm, q_push, q_ext, q_data, q_wr, q_pres;
    logic [1:0]        q_gate, q_cs_dpl, q_ss_dpl;
    logic [SEL_W-1:0]  q_sel, q_tbl;
    logic [ADDR_W-1:0] q_sp, q_ip;
    logic [LIM_W-1:0]  q_ss_lim, q_cs_lim;

    // result registers
    logic              r_fault;
    logic [7:0]        r_vec;
    logic [SEL_W-1:0]  r_err, r_ss;
    logic [ADDR_W-1:0] r_sp;

    // check unit outputs
    logic             is_null, sel_bad, desc_bad, not_present;
    logic [SEL_W-1:0] null_err, sel_err;
    logic             room_ok, sp_canon, ip_canon, ip_over, gate_wide;

    // step decision
    logic             chk_fail;
    logic [7:0]       chk_vec;
    logic [SEL_W-1:0] chk_err;

    ssw_seg_check #(.SEL_W(SEL_W)) u_seg (
        .sel(q_sel), .tbl_limit(q_tbl), .cs_dpl(q_cs_dpl), .ss_dpl(q_ss_dpl),
        .ss_is_data(q_data), .ss_writable(q_wr), .ss_present(q_pres), .ext_evt(q_ext),
        .is_null(is_null), .sel_bad(sel_bad), .desc_bad(desc_bad),
        .not_present(not_present), .null_err(null_err), .sel_err(sel_err)
    );

    ssw_room #(.LIM_W(LIM_W)) u_room (
        .gate_kind(q_gate), .push_err(q_push), .sp_lo(q_sp[LIM_W-1:0]),
        .seg_limit(q_ss_lim), .room_ok(room_ok)
    );

    ssw_canon #(.HI_W(HI_W)) u_sp_canon (
        .hi_bits(q_sp[ADDR_W-1:VA_BITS-1]), .canon_ok(sp_canon)
    );

    ssw_canon #(.HI_W(HI_W)) u_ip_canon (
        .hi_bits(q_ip[ADDR_W-1:VA_BITS-1]), .canon_ok(ip_canon)
    );

    always_comb begin
        gate_wide = q_gate[1];
        ip_over   = q_ip > {{(ADDR_W-LIM_W){1'b0}}, q_cs_lim};
    end

    // per-state check and next state
    always_comb begin
        chk_fail = 1'b0;
        chk_vec  = VEC_NONE;
        chk_err  = '0;
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start) state_nx = lm_active ? S_STACKCK : S_NULLCK;
            end
            S_NULLCK: begin
                chk_fail = is_null;
                chk_vec  = VEC_TS;
                chk_err  = null_err;
                state_nx = chk_fail ? S_REPORT : S_SELCK;
            end
            S_SELCK: begin
                chk_fail = sel_bad;
                chk_vec  = VEC_TS;
                chk_err  = sel_err;
                state_nx = chk_fail ? S_REPORT : S_DESCCK;
            end
            S_DESCCK: begin
                chk_fail = desc_bad;
                chk_vec  = VEC_TS;
                chk_err  = sel_err;
                state_nx = chk_fail ? S_REPORT : S_PRESCK;
            end
            S_PRESCK: begin
                chk_fail = not_present;
                chk_vec  = VEC_SS;
                chk_err  = sel_err;
                state_nx = chk_fail ? S_REPORT : S_STACKCK;
            end
            S_STACKCK: begin
                chk_fail = gate_wide ? !sp_canon : !room_ok;
                chk_vec  = VEC_SS;
                chk_err  = gate_wide ? '0 : sel_err;
                state_nx = chk_fail ? S_REPORT : S_IPCK;
            end
            S_IPCK: begin
                chk_fail = q_lm ? !ip_canon : ip_over;
                chk_vec  = VEC_GP;
                chk_err  = '0;
                state_nx = S_REPORT;
            end
            S_REPORT: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // request latch and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_lm <= 1'b0; q_push <= 1'b0; q_ext <= 1'b0; q_data <= 1'b0;
            q_wr <= 1'b0; q_pres <= 1'b0; q_gate <= '0; q_cs_dpl <= '0;
            q_ss_dpl <= '0; q_sel <= '0; q_tbl <= '0; q_sp <= '0; q_ip <= '0;
            q_ss_lim <= '0; q_cs_lim <= '0;
            r_fault <= 1'b0; r_vec <= VEC_NONE; r_err <= '0; r_ss <= '0; r_sp <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                q_lm <= lm_active; q_push <= push_err; q_ext <= ext_evt;
                q_data <= ss_is_data; q_wr <= ss_writable; q_pres <= ss_present;
                q_gate <= gate_kind; q_cs_dpl <= cs_dpl; q_ss_dpl <= ss_dpl;
                q_sel <= tss_sel; q_tbl <= tbl_limit; q_sp <= tss_sp; q_ip <= tgt_ip;
                q_ss_lim <= ss_limit; q_cs_lim <= cs_limit;
            end
            if (chk_fail) begin
                r_fault <= 1'b1;
                r_vec   <= chk_vec;
                r_err   <= chk_err;
                r_ss    <= '0;
                r_sp    <= '0;
            end else if (state == S_IPCK) begin
                r_fault <= 1'b0;
                r_vec   <= VEC_NONE;
                r_err   <= '0;
                r_ss    <= q_lm ? '0 : q_sel;
                r_sp    <= q_sp;
            end
        end
    end

    // outputs
    always_comb begin
        done     = (state == S_REPORT);
        fault    = r_fault;
        vector   = r_vec;
        err_code = r_err;
        new_ss   = r_ss;
        new_sp   = r_sp;
    end

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_REPORT) |=> state != S_IDLE);

    // R3
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (vector == VEC_TS || vector == VEC_SS || vector == VEC_GP));

    // R9
    gp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vector == VEC_GP) |-> err_code == '0);

    // R11
    ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (vector == VEC_NONE && err_code == '0 && new_sp == q_sp));

    // R11
    lm_ss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && q_lm) |-> new_ss == '0);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=> ($stable(vector) && $stable(new_sp) && $stable(fault)));
endmodule

// File: tb/test_stack_switch_checker.sv
module test_stack_switch_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        lm_active, push_err, ext_evt;
    logic [1:0]  gate_kind, cs_dpl, ss_dpl;
    logic [15:0] tss_sel, tbl_limit;
    logic [63:0] tss_sp, tgt_ip;
    logic        ss_is_data, ss_writable, ss_present;
    logic [31:0] ss_limit, cs_limit;
    logic        done, fault;
    logic [7:0]  vector;
    logic [15:0] err_code, new_ss;
    logic [63:0] new_sp;

    int n_chk = 0;
    int n_bad = 0;
    int lat;

    always #10 clk = ~clk;

    stack_switch_checker i_stack_switch_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .lm_active(lm_active),
        .gate_kind(gate_kind), .push_err(push_err), .ext_evt(ext_evt),
        .tss_sel(tss_sel), .tss_sp(tss_sp), .tbl_limit(tbl_limit), .cs_dpl(cs_dpl),
        .ss_dpl(ss_dpl), .ss_is_data(ss_is_data), .ss_writable(ss_writable),
        .ss_present(ss_present), .ss_limit(ss_limit), .tgt_ip(tgt_ip),
        .cs_limit(cs_limit), .done(done), .fault(fault), .vector(vector),
        .err_code(err_code), .new_ss(new_ss), .new_sp(new_sp)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic legacy_ok();
        lm_active = 0; gate_kind = 2'd1; push_err = 1; ext_evt = 0;
        tss_sel = 16'h0023; tss_sp = 64'h1000; tbl_limit = 16'h00FF;
        cs_dpl = 2'd3; ss_dpl = 2'd3; ss_is_data = 1; ss_writable = 1; ss_present = 1;
        ss_limit = 32'hFFFF; tgt_ip = 64'h100; cs_limit = 32'hFFFF;
    endtask

    task automatic lm_ok();
        legacy_ok();
        lm_active = 1; gate_kind = 2'd2; tss_sel = 16'h0000;
        tss_sp = 64'hFFFF_8000_0000_1000;
    endtask

    task automatic run(input bit poke);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0; lat = 1;
        while (!done && lat < 40) begin
            if (poke && lat == 3) begin start = 1; tss_sel = 16'h0000; tss_sp = 64'h5; end
            else start = 0;
            @(negedge clk); lat++;
        end
        start = 0;
        if (!done) chk("timeout", 0, 1);
    endtask

    task automatic expect_fault(input string tag, input logic [7:0] v, input logic [15:0] e);
        run(0);
        chk({tag, " fault"}, fault, 1);
        chk({tag, " vector"}, vector, v);
        chk({tag, " err"}, err_code, e);
    endtask

    task automatic expect_pass(input string tag, input logic [15:0] ss);
        run(0);
        chk({tag, " fault"}, fault, 0);
        chk({tag, " new_ss"}, new_ss, ss);
        chk({tag, " new_sp"}, new_sp, tss_sp);
    endtask

    task automatic t_reset();
        chk("R1 done", done, 0); chk("R1 fault", fault, 0); chk("R1 vector", vector, 0);
        chk("R1 err", err_code, 0); chk("R1 ss", new_ss, 0); chk("R1 sp", new_sp, 0);
    endtask

    task automatic t_latency();
        legacy_ok(); run(0);
        chk("R2 legacy latency", lat, 7);
        chk("R11 legacy ok", fault, 0);
        chk("R11 vector", vector, 0);
        chk("R11 new_ss", new_ss, 16'h0023);
        chk("R11 new_sp", new_sp, 64'h1000);
        @(negedge clk); chk("R2 done one cycle", done, 0);
        lm_ok(); run(0);
        chk("R2 lm latency", lat, 3);
        chk("R11 lm new_ss", new_ss, 0);
        chk("R11 lm new_sp", new_sp, 64'hFFFF_8000_0000_1000);
    endtask

    task automatic t_busy_hold();
        legacy_ok(); run(1);
        chk("R2 busy start latency", lat, 7);
        chk("R2 busy start fault", fault, 0);
        chk("R2 busy start sp", new_sp, 64'h1000);
        repeat (4) @(negedge clk);
        chk("R12 hold done", done, 0);
        chk("R12 hold sp", new_sp, 64'h1000);
        chk("R12 hold ss", new_ss, 16'h0023);
    endtask

    task automatic t_null();
        legacy_ok(); tss_sel = 16'h0000; ext_evt = 1; expect_fault("R3 null ext", 10, 16'h0001);
        legacy_ok(); tss_sel = 16'h0003; expect_fault("R3 null rpl3", 10, 16'h0000);
    endtask

    task automatic t_sel();
        legacy_ok(); tbl_limit = 16'h001F; expect_fault("R4 range", 10, 16'h0020);
        legacy_ok(); tbl_limit = 16'h001F; ext_evt = 1; expect_fault("R4 range ext", 10, 16'h0021);
        legacy_ok(); tbl_limit = 16'h0027; expect_pass("R4 range edge", 16'h0023);
        legacy_ok(); tss_sel = 16'h0022; expect_fault("R4 rpl", 10, 16'h0020);
    endtask

    task automatic t_desc();
        legacy_ok(); ss_dpl = 2'd2; expect_fault("R5 dpl", 10, 16'h0020);
        legacy_ok(); ss_writable = 0; expect_fault("R5 ro", 10, 16'h0020);
        legacy_ok(); ss_is_data = 0; expect_fault("R5 code", 10, 16'h0020);
        legacy_ok(); ss_present = 0; expect_fault("R6 absent", 12, 16'h0020);
    endtask

    task automatic t_room();
        legacy_ok(); tss_sp = 24; expect_pass("R7 g32e 24", 16'h0023);
        legacy_ok(); tss_sp = 23; expect_fault("R7 g32e 23", 12, 16'h0020);
        legacy_ok(); push_err = 0; tss_sp = 20; expect_pass("R7 g32 20", 16'h0023);
        legacy_ok(); push_err = 0; tss_sp = 19; expect_fault("R7 g32 19", 12, 16'h0020);
        legacy_ok(); gate_kind = 0; tss_sp = 12; expect_pass("R7 g16e 12", 16'h0023);
        legacy_ok(); gate_kind = 0; tss_sp = 11; expect_fault("R7 g16e 11", 12, 16'h0020);
        legacy_ok(); gate_kind = 0; push_err = 0; tss_sp = 10; expect_pass("R7 g16 10", 16'h0023);
        legacy_ok(); gate_kind = 0; push_err = 0; tss_sp = 9; expect_fault("R7 g16 9", 12, 16'h0020);
        legacy_ok(); tss_sp = 64'h10000; expect_pass("R7 top edge", 16'h0023);
        legacy_ok(); tss_sp = 64'h10001; expect_fault("R7 over top", 12, 16'h0020);
    endtask

    task automatic t_canon();
        lm_ok(); tss_sp = 64'h0000_7FFF_FFFF_FFF0; expect_pass("R8 low canon", 0);
        lm_ok(); tss_sp = 64'h0000_8000_0000_0000; expect_fault("R8 noncanon", 12, 0);
        lm_ok(); tss_sp = 64'hFFFF_8000_0000_0000; expect_pass("R8 high canon", 0);
        lm_ok(); tss_sel = 16'h0000; ss_present = 0; ss_dpl = 0; expect_pass("R11 lm skips seg", 0);
    endtask

    task automatic t_ip();
        legacy_ok(); tgt_ip = 64'hFFFF; expect_pass("R9 ip edge", 16'h0023);
        legacy_ok(); tgt_ip = 64'h10000; expect_fault("R9 ip over", 13, 0);
        lm_ok(); tgt_ip = 64'h0001_0000_0000_0000; expect_fault("R9 lm ip", 13, 0);
    endtask

    task automatic t_prio();
        legacy_ok(); ss_dpl = 2'd1; ss_present = 0; expect_fault("R10 desc before pres", 10, 16'h0020);
        legacy_ok(); tss_sp = 5; tgt_ip = 64'h20000; expect_fault("R10 stack before ip", 12, 16'h0020);
        legacy_ok(); tss_sel = 16'h0001; ext_evt = 1; ss_present = 0; tgt_ip = 64'h20000;
        expect_fault("R10 null first", 10, 16'h0001);
        legacy_ok(); ss_present = 0; tss_sp = 3; expect_fault("R10 pres before room", 12, 16'h0020);
    endtask

    initial begin
        legacy_ok();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_latency();
        t_busy_hold();
        t_null();
        t_sel();
        t_desc();
        t_room();
        t_canon();
        t_ip();
        t_prio();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule